// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Wired Line Resolution

The block models a general-purpose I/O port whose pin levels are the wired combination of three sources: values the CPU drives, values an attached peripheral drives, and per-pin pull-up resistors. Software reaches it through a small register bus. A 32-bit control word holds, for every pin, an output-enable bit next to a pull-up enable bit. A 16-bit data word holds the CPU drive values. A 16-bit interrupt-control word is stored and read back but never acts on anything. The peripheral side is a pair of 16-bit inputs carrying that side's drive values and output enables.

Reads of the data word return the resolved pin levels, not the latched CPU values. Every write to the control or data word compares the resolved levels just before the write with those just after it. When they differ, the block raises a one-cycle change pulse with the XOR mask. It also raises a notify line for each peripheral whose trigger mask overlaps that XOR mask, so the peripheral can respond by updating its own drive inputs.

Top module: `gpio_port_resolved`

## Requirements
- R1: After a synchronous active-low reset, the control, data and interrupt-control words are zero. All pins therefore read 0 while the peripheral drives nothing. The change pulse, change mask and notify lines are 0.
- R2: For pin n, control bit 2n is the CPU output enable and control bit 2n+1 is the pull-up enable. A pin with only its pull-up enabled reads 1.
- R3: Level of a pin = (CPU enable AND CPU data) OR (peripheral enable AND peripheral data) OR (NOT(CPU enable OR peripheral enable) AND pull-up). A pin with no driver and no pull-up reads 0.
- R4: A read of the data word (word address 1) returns the resolved levels in bits 15:0, not the stored CPU data.
- R5: A write to the control word (address 0) or the data word (address 1) that changes any resolved level raises chg_pulse in the cycle after the write edge. In that same cycle chg_mask holds the XOR of the levels before and after the write.
- R6: A control or data write that leaves every level unchanged raises no pulse. chg_mask is zero whenever chg_pulse is low.
- R7: Peripheral i owns bits [16i+15:16i] of trig_mask. Its notify[i] rises together with chg_pulse only when its trigger mask ANDed with the change mask is nonzero.
- R8: A write to the interrupt-control word (address 2) stores bits 15:0, which read back at address 2. It leaves the pins unchanged and raises no pulse.
- R9: The control word reads back all 32 written bits. Data write bits 31:16 are dropped. Data and interrupt-control reads return zero in bits 31:16. Read data appears in the cycle after the read edge.
- R10: chg_pulse rises only after a register write. A change on the peripheral inputs alone alters pins but raises no pulse, and each pulse lasts one cycle unless the next write also changes the levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address: 0 control, 1 data, 2 interrupt control |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| periph_dir | input | 16 | Peripheral output enables |
| periph_val | input | 16 | Peripheral drive values |
| trig_mask | input | 32 | Per-peripheral trigger masks, 16 bits each |
| pins | output | 16 | Resolved pin levels |
| chg_pulse | output | 1 | One-cycle level-change indication |
| chg_mask | output | 16 | Pins that changed on the last write |
| notify | output | 2 | Per-peripheral change notification |

## Verification
If the control bits were split into direction and pull-up in the wrong order, the pins output would be wrong in the first cycle after the control write. A data read would show the same error one cycle later. A fault in the before-and-after comparison would appear as a wrong or missing chg_pulse in the cycle right after the offending write. The notify lines would show the same fault in that cycle. A stale or misrouted register shows up only when a read or the next pin-affecting write exposes it, which is why the stimulus reads back after every write sequence.

// File: rtl/gpio_port_pkg.sv
// Package: shared constants for the GPIO port.
// Assumes word addressing on the register bus.
package gpio_port_pkg;
    localparam int PIN_COUNT    = 16;
    localparam int PERIPH_COUNT = 2;
    localparam int ADDR_BITS    = 2;
    localparam int ADR_CTRL     = 0;
    localparam int ADR_DATA     = 1;
    localparam int ADR_INTCTL   = 2;
endpackage

// File: rtl/gpio_ctrl_split.sv
// Splits the interleaved control word into per-pin output-enable and
// pull-up vectors. Even bits are enables, odd bits are pull-ups.
module gpio_ctrl_split #(
    parameter int PINS = 16
) (
    input  logic [2*PINS-1:0] ctrl,
    output logic [PINS-1:0]   dir_en,
    output logic [PINS-1:0]   pull_en
);
    // Purpose: route bit 2n to enable n and bit 2n+1 to pull-up n.
    for (genvar n = 0; n < PINS; n++) begin : g_pin
        assign dir_en[n]  = ctrl[2*n];
        assign pull_en[n] = ctrl[2*n+1];
    end
endmodule

// File: rtl/gpio_resolve.sv
// Wired resolution of CPU drive, peripheral drive and pull-ups.
// Purely combinational; assumes drivers never fight (the levels are ORed).
module gpio_resolve #(
    parameter int PINS = 16
) (
    input  logic [PINS-1:0] cpu_dir,
    input  logic [PINS-1:0] cpu_val,
    input  logic [PINS-1:0] per_dir,
    input  logic [PINS-1:0] per_val,
    input  logic [PINS-1:0] pull_en,
    output logic [PINS-1:0] level
);
    // Purpose: combine the three sources into the pin level.
    always_comb begin
        level = (cpu_dir & cpu_val)
              | (per_dir & per_val)
              | (~(cpu_dir | per_dir) & pull_en);
    end
endmodule

// File: rtl/gpio_change_track.sv
// Registers the change pulse, change mask and per-peripheral notify lines
// for a pin-affecting write. Assumes the before/after levels come from
// the same cycle as the write strobe.
module gpio_change_track #(
    parameter int PINS = 16,
    parameter int NPER = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [PINS-1:0]  lvl_before,
    input  logic [PINS-1:0]  lvl_after,
    input  logic [NPER*PINS-1:0] trig_mask,
    output logic             chg_pulse,
    output logic [PINS-1:0]  chg_mask,
    output logic [NPER-1:0]  notify
);
    logic [PINS-1:0] diff;
    logic [NPER-1:0] hit;

    // Purpose: XOR of the levels around the write.
    assign diff = upd ? (lvl_before ^ lvl_after) : '0;

    // Purpose: per-peripheral overlap of trigger mask with the change.
    for (genvar i = 0; i < NPER; i++) begin : g_per
        assign hit[i] = |(trig_mask[i*PINS +: PINS] & diff);
    end

    // Purpose: register the indication for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chg_pulse <= 1'b0;
            chg_mask  <= '0;
            notify    <= '0;
        end else begin
            chg_pulse <= |diff;
            chg_mask  <= diff;
            notify    <= hit;
        end
    end
endmodule

// File: rtl/gpio_port_resolved.sv
// GPIO port top: register file, resolution of current and post-write
// levels, change tracking and registered read data.
// Assumes peripheral inputs are stable across a register write cycle.
module gpio_port_resolved #(
    parameter int PINS   = gpio_port_pkg::PIN_COUNT,
    parameter int NPER   = gpio_port_pkg::PERIPH_COUNT,
    parameter int ADDR_W = gpio_port_pkg::ADDR_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [2*PINS-1:0]    bus_wdata,
    output logic [2*PINS-1:0]    bus_rdata,
    input  logic [PINS-1:0]      periph_dir,
    input  logic [PINS-1:0]      periph_val,
    input  logic [NPER*PINS-1:0] trig_mask,
    output logic [PINS-1:0]      pins,
    output logic                 chg_pulse,
    output logic [PINS-1:0]      chg_mask,
    output logic [NPER-1:0]      notify
);
    localparam int CTRL_W = 2 * PINS;
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(gpio_port_pkg::ADR_CTRL);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(gpio_port_pkg::ADR_DATA);
    localparam logic [ADDR_W-1:0] A_ICTL = ADDR_W'(gpio_port_pkg::ADR_INTCTL);

    logic [CTRL_W-1:0] ctrl_q, ctrl_nx;
    logic [PINS-1:0]   data_q, data_nx;
    logic [PINS-1:0]   intctl_q;
    logic [PINS-1:0]   cur_dir, cur_pull, nx_dir, nx_pull, nx_level;
    logic              wr_ctrl, wr_data, wr_ictl, rd_any;

    // Purpose: decode the bus strobe into per-register write enables.
    always_comb begin
        wr_ctrl = bus_valid && bus_write && (bus_addr == A_CTRL);
        wr_data = bus_valid && bus_write && (bus_addr == A_DATA);
        wr_ictl = bus_valid && bus_write && (bus_addr == A_ICTL);
        rd_any  = bus_valid && !bus_write;
    end

    // Purpose: register contents as they will be after this cycle.
    always_comb begin
        ctrl_nx = wr_ctrl ? bus_wdata : ctrl_q;
        data_nx = wr_data ? bus_wdata[PINS-1:0] : data_q;
    end

    gpio_ctrl_split #(.PINS(PINS)) u_split_cur (
        .ctrl(ctrl_q), .dir_en(cur_dir), .pull_en(cur_pull)
    );
    gpio_ctrl_split #(.PINS(PINS)) u_split_nx (
        .ctrl(ctrl_nx), .dir_en(nx_dir), .pull_en(nx_pull)
    );

    gpio_resolve #(.PINS(PINS)) u_res_cur (
        .cpu_dir(cur_dir), .cpu_val(data_q),
        .per_dir(periph_dir), .per_val(periph_val),
        .pull_en(cur_pull), .level(pins)
    );
    gpio_resolve #(.PINS(PINS)) u_res_nx (
        .cpu_dir(nx_dir), .cpu_val(data_nx),
        .per_dir(periph_dir), .per_val(periph_val),
        .pull_en(nx_pull), .level(nx_level)
    );

    gpio_change_track #(.PINS(PINS), .NPER(NPER)) u_track (
        .clk(clk), .rst_n(rst_n), .upd(wr_ctrl || wr_data),
        .lvl_before(pins), .lvl_after(nx_level), .trig_mask(trig_mask),
        .chg_pulse(chg_pulse), .chg_mask(chg_mask), .notify(notify)
    );

    // Purpose: hold the software-visible registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            data_q   <= '0;
            intctl_q <= '0;
        end else begin
            ctrl_q <= ctrl_nx;
            data_q <= data_nx;
            if (wr_ictl) intctl_q <= bus_wdata[PINS-1:0];
        end
    end

    // Purpose: registered read mux; data reads return resolved levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_any) begin
            if (bus_addr == A_CTRL)      bus_rdata <= ctrl_q;
            else if (bus_addr == A_DATA) bus_rdata <= CTRL_W'(pins);
            else if (bus_addr == A_ICTL) bus_rdata <= CTRL_W'(intctl_q);
            else                         bus_rdata <= '0;
        end
    end
endmodule

// File: rtl/gpio_port_checker.sv
// Checker for the GPIO port, attached by bind. Observes ports and the
// decoded control vectors; assumes synchronous active-low reset.
module gpio_port_checker #(
    parameter int PINS   = 16,
    parameter int NPER   = 2,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              chg_pulse,
    input logic [PINS-1:0]   chg_mask,
    input logic [NPER-1:0]   notify,
    input logic [PINS-1:0]   pins,
    input logic [PINS-1:0]   cpu_dir,
    input logic [PINS-1:0]   pull_en,
    input logic [PINS-1:0]   periph_dir
);
    localparam logic [ADDR_W-1:0] A_ICTL = ADDR_W'(gpio_port_pkg::ADR_INTCTL);

    AST_UNDRIVEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pins & ~(cpu_dir | periph_dir | pull_en)) == '0); // R3
    AST_PULLUP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_en & ~cpu_dir & ~periph_dir & ~pins) == '0); // R2
    AST_PULSE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        chg_pulse |-> $past(bus_valid && bus_write)); // R10
    AST_MASK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        chg_pulse |-> (chg_mask != '0)); // R6
    AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !chg_pulse |-> (chg_mask == '0)); // R6
    AST_NOTIFY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (notify != '0) |-> chg_pulse); // R7
    AST_INTCTL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == A_ICTL) |=> !chg_pulse); // R8
endmodule

bind gpio_port_resolved gpio_port_checker #(
    .PINS(PINS), .NPER(NPER), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .chg_pulse(chg_pulse), .chg_mask(chg_mask),
    .notify(notify), .pins(pins), .cpu_dir(cur_dir), .pull_en(cur_pull),
    .periph_dir(periph_dir)
);

// File: tb/tb_gpio_port_resolved.sv
module tb_gpio_port_resolved;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 9;
    // fields: ctrl[95:64] data[63:48] pdir[47:32] pval[31:16] expected[15:0]
    localparam logic [95:0] VEC [NV] = '{
        {32'h0000_0000, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000},
        {32'hAAAA_AAAA, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF},
        {32'h5555_5555, 16'h1234, 16'h0000, 16'h0000, 16'h1234},
        {32'h5555_5555, 16'h00F0, 16'h0F00, 16'h0300, 16'h03F0},
        {32'h0000_FFFF, 16'h00A5, 16'h0000, 16'h0000, 16'h00A5},
        {32'hFFFF_0000, 16'h1200, 16'h0000, 16'h0000, 16'h1200},
        {32'hAAAA_0000, 16'hFFFF, 16'h00FF, 16'h0081, 16'hFF81},
        {32'hAAAA_AAAA, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000},
        {32'h0000_0001, 16'h0001, 16'h0002, 16'h0002, 16'h0003}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] periph_dir = '0, periph_val = '0;
    logic [31:0] trig_mask = {16'hFF00, 16'h0001};
    logic [15:0] pins, chg_mask;
    logic        chg_pulse;
    logic [1:0]  notify;

    int total = 0, bad = 0;
    logic        s_pulse;
    logic [15:0] s_mask;
    logic [1:0]  s_notify;

    gpio_port_resolved dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .periph_dir(periph_dir), .periph_val(periph_val), .trig_mask(trig_mask),
        .pins(pins), .chg_pulse(chg_pulse), .chg_mask(chg_mask), .notify(notify)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        s_pulse = chg_pulse; s_mask = chg_mask; s_notify = notify;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 pins", 32'(pins), 32'h0);
        check("R1 pulse", 32'(chg_pulse), 32'h0);
        rd(2'd0, r); check("R1 ctrl", r, 32'h0);
        rd(2'd1, r); check("R1 data", r, 32'h0);
        rd(2'd2, r); check("R1 intctl", r, 32'h0);
        // R2 pull-up on odd bit of pin 0
        wr(2'd0, 32'h0000_0002);
        check("R2 pins", 32'(pins), 32'h0001);
        check("R5 pulse", 32'(s_pulse), 32'h1);
        check("R5 mask", 32'(s_mask), 32'h0001);
        check("R7 notify p0", 32'(s_notify), 32'h1);
        @(negedge clk);
        check("R10 single cycle", 32'(chg_pulse), 32'h0);
        // R2 pull-up on pin 15, pin 0 released
        wr(2'd0, 32'h8000_0000);
        check("R2 pin15", 32'(pins), 32'h8000);
        check("R5 mask two pins", 32'(s_mask), 32'h8001);
        check("R7 notify both", 32'(s_notify), 32'h3);
        // R6 data write with no enables changes nothing
        wr(2'd1, 32'h0000_1234);
        check("R6 no pulse", 32'(s_pulse), 32'h0);
        check("R6 mask zero", 32'(s_mask), 32'h0);
        rd(2'd1, r); check("R4 resolved read", r, 32'h0000_8000);
        // R5 control write enabling pins 0,1 drops pull-up on 15
        wr(2'd0, 32'h0000_0005);
        check("R5 ctrl change", 32'(s_mask), 32'h8000);
        check("R7 notify p1", 32'(s_notify), 32'h2);
        // R5/R9 data write, upper bits dropped
        wr(2'd1, 32'hFFFF_0003);
        check("R5 data change", 32'(s_mask), 32'h0003);
        check("R7 notify p0 only", 32'(s_notify), 32'h1);
        rd(2'd1, r); check("R9 data upper zero", r, 32'h0000_0003);
        // R8 interrupt-control stored, no effect
        wr(2'd2, 32'h0000_BEEF);
        check("R8 no pulse", 32'(s_pulse), 32'h0);
        check("R8 pins kept", 32'(pins), 32'h0003);
        rd(2'd2, r); check("R8 readback", r, 32'h0000_BEEF);
        // R10 peripheral change alone: pins move, no pulse; R3 periph drive
        @(negedge clk);
        periph_dir = 16'h0010; periph_val = 16'h0010;
        @(negedge clk);
        check("R3 periph drive", 32'(pins), 32'h0013);
        @(negedge clk);
        check("R10 no pulse on periph", 32'(chg_pulse), 32'h0);
        // R9 control full readback
        wr(2'd0, 32'h1234_5678);
        rd(2'd0, r); check("R9 ctrl readback", r, 32'h1234_5678);
        // R3 table of resolution patterns
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            periph_dir = VEC[i][47:32]; periph_val = VEC[i][31:16];
            wr(2'd0, VEC[i][95:64]);
            wr(2'd1, {16'h0, VEC[i][63:48]});
            rd(2'd1, r);
            check($sformatf("R3 vec%0d read", i), r, {16'h0, VEC[i][15:0]});
            check($sformatf("R3 vec%0d pins", i), 32'(pins), 32'(VEC[i][15:0]));
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule